// File: doc/BRIEF.md
# Fractional-Nanosecond System Timer

This block keeps a 64-bit running time count in scaled units. The top 45 bits hold whole nanoseconds and the bottom 19 bits hold fractions of a nanosecond, so one count unit is 2^-19 ns. A small tick generator fires once every `period` clock cycles. On each tick the count grows by a programmable 24-bit step: 5 bits of whole nanoseconds and 19 bits of fraction. Software trims the clock rate by nudging the step up or down. One unit of step is close to 0.12 ppm of the nominal 16 ns step.

Software reaches the block through a 2-bit word-addressed register port.

- Address 0 is the low time word and address 1 is the high time word.
- Address 2 is the increment register.
- Reading the low word freezes the matching high word, so a low-then-high read pair returns a coherent 64-bit value.
- Writing the low word only stages it. The later write of the high word loads all 64 bits in one cycle.

Top module: `systim_top`

## Requirements
- R1: After reset the time count is zero, no high word is frozen, and the increment register reads 0x0180_0000. That value is period 1 in bits 31:24 and step 16 ns (0x80_0000) in bits 23:0.
- R2: While the period field P is non-zero, the count advances by exactly the step field once every P clock cycles and holds in the cycles between. With P = 1 it advances every cycle.
- R3: While the period field is zero, the count does not change.
- R4: Writing address 2 sets the period (bits 31:24) and step (bits 23:0) and restarts the tick phase. The tick in the write cycle still uses the old settings. Address 2 reads back the stored word.
- R5: A write to address 0 changes nothing visible. It only stages the low word. A write to address 1 loads {written high word, staged low word} into the count on that edge and restarts the tick phase.
- R6: A read of address 0 returns bits 31:0 of the count and freezes bits 63:32 as they were at the same edge. A later read of address 1 returns the frozen word however far the count has moved since.
- R7: A read of address 1 clears the frozen word. With nothing frozen, address 1 returns the live bits 63:32. Every new read of address 0 refreshes the frozen word.
- R8: The count wraps modulo 2^64.
- R9: Read data appears on `rdata` one cycle after the read strobe and holds until the next read. Address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Word address: 0 low time, 1 high time, 2 increment, 3 unused |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |

## Verification
The bench goes after the coherence of split reads. It places the count just below a low-word carry, reads the low word, lets the carry happen, and then expects the old high word. A design that latched nothing, or latched on the high read, would return the incremented word. The bench also programs a period of 3 and a period of 0: an off-by-one tick counter drifts from the model within a few ticks, and a zero period that still ticks changes a value that must stay frozen. A staged low write is checked to leave the count untouched until the high write. A load near 2^64 checks that the count wraps instead of saturating.

// File: rtl/systim_pkg.sv
package systim_pkg;
  typedef enum logic [1:0] {
    A_TIME_LO = 2'd0,
    A_TIME_HI = 2'd1,
    A_INCR    = 2'd2,
    A_SPARE   = 2'd3
  } reg_addr_e;

  // Step in units of 2^-19 ns: 16 ns nominal.
  function automatic logic [23:0] nominal_step(input int frac_bits);
    return 24'(32'd16 << frac_bits);
  endfunction

  // Add a zero-extended step to the 64-bit count (wraps modulo 2^64).
  function automatic logic [63:0] time_plus(input logic [63:0] t, input logic [23:0] s);
    return t + {40'd0, s};
  endfunction
endpackage

// File: rtl/systim_tick.sv
module systim_tick #(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] period,
  input  logic             restart,
  output logic             tick
);
  logic [PER_W-1:0] phase;

  assign tick = (period != '0) && (phase == period - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n)               phase <= '0;
    else if (restart || tick) phase <= '0;
    else if (period != '0)    phase <= phase + 1'b1;
  end
endmodule

// File: rtl/systim_accum.sv
module systim_accum
  import systim_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int STEP_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tload,
  input  logic [TIME_W-1:0] load_val,
  input  logic              tick,
  input  logic [STEP_W-1:0] step,
  output logic [TIME_W-1:0] sys_time
);
  always_ff @(posedge clk) begin
    if (!rst_n)      sys_time <= '0;
    else if (tload)  sys_time <= load_val;
    else if (tick)   sys_time <= time_plus(sys_time, step);
  end
endmodule

// File: rtl/systim_readport.sv
module systim_readport #(
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_lo,
  input  logic                rd_hi,
  input  logic                rd_inc,
  input  logic                rd_spare,
  input  logic [2*WORD_W-1:0] sys_time,
  input  logic [WORD_W-1:0]   inc_word,
  output logic [WORD_W-1:0]   rdata,
  output logic                hold_valid,
  output logic [WORD_W-1:0]   held
);
  logic [WORD_W-1:0] live_hi;
  assign live_hi = sys_time[2*WORD_W-1:WORD_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata      <= '0;
      hold_valid <= 1'b0;
      held       <= '0;
    end else begin
      if (rd_lo) begin
        rdata      <= sys_time[WORD_W-1:0];
        held       <= live_hi;
        hold_valid <= 1'b1;
      end else if (rd_hi) begin
        rdata      <= hold_valid ? held : live_hi;
        hold_valid <= 1'b0;
      end else if (rd_inc) begin
        rdata      <= inc_word;
      end else if (rd_spare) begin
        rdata      <= '0;
      end
    end
  end
endmodule

// File: rtl/systim_top.sv
module systim_top
  import systim_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int PER_W     = 8,
  parameter int STEP_W    = 24,
  parameter int FRAC_BITS = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  localparam int TIME_W = 2 * WORD_W;
  localparam logic [WORD_W-1:0] INC_RESET =
    {PER_W'(1), nominal_step(FRAC_BITS)};

  reg_addr_e         a;
  logic              wr_lo, wr_hi, wr_inc;
  logic              rd_lo, rd_hi, rd_inc, rd_spare;
  logic [WORD_W-1:0] inc_q, lo_stage, held;
  logic [PER_W-1:0]  period;
  logic [STEP_W-1:0] step;
  logic              tick, tload, hold_valid;
  logic [TIME_W-1:0] load_val, sys_time;

  assign a        = reg_addr_e'(addr);
  assign wr_lo    = wr_en && (a == A_TIME_LO);
  assign wr_hi    = wr_en && (a == A_TIME_HI);
  assign wr_inc   = wr_en && (a == A_INCR);
  assign rd_lo    = rd_en && (a == A_TIME_LO);
  assign rd_hi    = rd_en && (a == A_TIME_HI);
  assign rd_inc   = rd_en && (a == A_INCR);
  assign rd_spare = rd_en && (a == A_SPARE);

  assign period   = inc_q[WORD_W-1:STEP_W];
  assign step     = inc_q[STEP_W-1:0];
  assign tload    = wr_hi;
  assign load_val = {wdata, lo_stage};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inc_q    <= INC_RESET;
      lo_stage <= '0;
    end else begin
      if (wr_inc) inc_q    <= wdata;
      if (wr_lo)  lo_stage <= wdata;
    end
  end

  systim_tick #(.PER_W(PER_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .period(period),
    .restart(wr_inc || wr_hi), .tick(tick)
  );

  systim_accum #(.TIME_W(TIME_W), .STEP_W(STEP_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .tload(tload), .load_val(load_val),
    .tick(tick), .step(step), .sys_time(sys_time)
  );

  systim_readport #(.WORD_W(WORD_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_lo(rd_lo), .rd_hi(rd_hi),
    .rd_inc(rd_inc), .rd_spare(rd_spare), .sys_time(sys_time),
    .inc_word(inc_q), .rdata(rdata), .hold_valid(hold_valid), .held(held)
  );
endmodule

// File: rtl/systim_checks.sv
module systim_checks #(
  parameter int WORD_W = 32,
  parameter int PER_W  = 8,
  parameter int STEP_W = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tick,
  input logic                tload,
  input logic [2*WORD_W-1:0] load_val,
  input logic [2*WORD_W-1:0] sys_time,
  input logic [STEP_W-1:0]   step,
  input logic [PER_W-1:0]    period,
  input logic                rd_lo,
  input logic                rd_hi,
  input logic                hold_valid,
  input logic [WORD_W-1:0]   held
);
  assert_no_tick_at_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (period == '0) |-> !tick);

  assert_step_added_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !tload) |=> sys_time == $past(sys_time) + {{(2*WORD_W-STEP_W){1'b0}}, $past(step)});

  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !tload) |=> $stable(sys_time));

  assert_load_whole_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tload |=> sys_time == $past(load_val));

  assert_low_read_freezes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |=> hold_valid && held == $past(sys_time[2*WORD_W-1:WORD_W]));

  assert_high_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hi && !rd_lo) |=> !hold_valid);

  assert_frozen_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_valid && !rd_lo && !rd_hi) |=> $stable(held) && hold_valid);
endmodule

bind systim_top systim_checks #(.WORD_W(WORD_W), .PER_W(PER_W), .STEP_W(STEP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .tload(tload), .load_val(load_val),
  .sys_time(sys_time), .step(step), .period(period), .rd_lo(rd_lo),
  .rd_hi(rd_hi), .hold_valid(hold_valid), .held(held)
);

// File: tb/systim_top_test.sv
module systim_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  systim_top uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
                  .addr(addr), .wdata(wdata), .rdata(rdata));

  // Behavioural reference model
  longint unsigned m_time;
  int unsigned     m_per, m_step, m_phase;
  logic [31:0]     m_stage, m_hold, m_rd;
  bit              m_hold_v;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_time = 0; m_per = 1; m_step = 16 << 19; m_phase = 0;
      m_stage = 0; m_hold = 0; m_hold_v = 0; m_rd = 0;
    end else begin
      if (rd_en) begin
        case (addr)
          2'd0: begin m_rd = m_time[31:0]; m_hold = m_time[63:32]; m_hold_v = 1; end
          2'd1: begin m_rd = m_hold_v ? m_hold : m_time[63:32]; m_hold_v = 0; end
          2'd2: m_rd = {m_per[7:0], m_step[23:0]};
          default: m_rd = 0;
        endcase
      end
      if (m_per != 0) begin
        m_phase++;
        if (m_phase == m_per) begin
          m_phase = 0;
          if (!(wr_en && addr == 2'd1)) m_time = m_time + m_step;
        end
      end
      if (wr_en && addr == 2'd0) m_stage = wdata;
      if (wr_en && addr == 2'd1) begin m_time = {wdata, m_stage}; m_phase = 0; end
      if (wr_en && addr == 2'd2) begin m_per = wdata[31:24]; m_step = wdata[23:0]; m_phase = 0; end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Every-cycle comparison of the read port against the model
  always @(negedge clk) if (rst_n && !done) check("R9 per-cycle rdata", rdata, m_rd);

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, input string tag, output logic [31:0] v);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0;
    v = rdata;
    check(tag, v, m_rd);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 rdata after reset", rdata, 32'h0);
    rd(2'd2, "R1 increment reset", v);
    check("R1 increment reset literal", v, 32'h0180_0000);
    rd(2'd0, "R1/R2 nominal low", v);
    rd(2'd1, "R2 nominal high", v);

    wr(2'd2, 32'h0312_3456);
    idle(10);
    rd(2'd2, "R4 increment readback", v);
    check("R4 increment literal", v, 32'h0312_3456);
    for (int i = 0; i < 6; i++) begin
      rd(2'd0, "R2 period 3 low", v);
      idle(i);
    end

    wr(2'd2, 32'h0000_0100);
    rd(2'd0, "R3 frozen low a", v);
    idle(20);
    rd(2'd0, "R3 frozen low b", v2);
    check("R3 no advance", v2, v);

    wr(2'd0, 32'hDEAD_BEEF);
    idle(3);
    rd(2'd0, "R5 staged write invisible", v2);
    check("R5 staged write literal", v2, v);
    wr(2'd1, 32'h0000_0012);
    rd(2'd0, "R5 loaded low", v);
    check("R5 loaded low literal", v, 32'hDEAD_BEEF);
    rd(2'd1, "R5 loaded high", v);
    check("R5 loaded high literal", v, 32'h0000_0012);

    wr(2'd2, 32'h0180_0000);
    wr(2'd0, 32'hFFE0_0000);
    wr(2'd1, 32'hFFFF_FFFF);
    idle(4);
    rd(2'd0, "R8 wrap low", v);
    rd(2'd1, "R8 wrap high", v);
    check("R8 wrap high literal", v, 32'h0);

    wr(2'd2, 32'h0100_0010);
    wr(2'd0, 32'hFFFF_FF00);
    wr(2'd1, 32'h0000_0005);
    rd(2'd0, "R6 low before carry", v);
    idle(30);
    rd(2'd1, "R6 frozen high", v);
    check("R6 frozen high literal", v, 32'h5);
    rd(2'd1, "R7 live high", v);
    check("R7 live high literal", v, 32'h6);
    rd(2'd0, "R7 refresh low", v);
    rd(2'd1, "R7 refreshed high", v);
    check("R7 refreshed literal", v, 32'h6);

    rd(2'd3, "R9 spare", v);
    check("R9 spare literal", v, 32'h0);
    idle(3);
    check("R9 rdata holds", rdata, 32'h0);

    wr(2'd2, 32'h0380_0000);
    for (int i = 0; i < 8; i++) begin
      rd(2'd0, "R2 mixed low", v);
      rd(2'd1, "R6 mixed high", v);
      idle(i % 3);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule